// File: doc/BRIEF.md
# Guarded Data EEPROM Controller

This block sits on a small CPU register bus and fronts an on-chip byte array that behaves like data EEPROM. Software sees four byte-wide registers: an address register, a data register, a control register and a write-only key register. A read is requested with a control bit and lands the addressed byte in the data register. A write copies the data register into the addressed location, but only after a guarded unlock ritual. After launch a fixed programming delay runs, and then a sticky completion flag drives an interrupt request.

The guard has several layers, and all of them must agree before a byte is programmed. Software must write 0x55 and then 0xAA to the key register and then request the write. Each step must land exactly `KEY_GAP` clock cycles after the step before it. The write-enable bit must already be set when the request arrives. No write can launch during a lockout window of `LOCK_CYCLES` cycles after reset. The array is a register array, and the programming time is `WRITE_CYCLES` clock cycles.

Register offsets on `busAddr`: 0 address, 1 data, 2 control, 3 key (reads as 0). Control bit layout: bit0 read request/read pulse, bit1 write busy, bit2 write enable, bit3 write done.

Top module: `eeprom_guard`

## Requirements
- R1: After reset, the address, data and control registers read 0x00, `irq` is low, and every array byte is 0x00.
- R2: A control write with bit0=1 while no write is busy loads the data register from the array at the edge of that bus write. In the following cycle control bit0 reads 1, and it reads 0 in the cycle after.
- R3: The data register holds its value until a bus write to offset 1 or an accepted read changes it.
- R4: A write launches only when the key register receives 0x55, then 0xAA, and then a control write with bit1=1 follows. Any key write whose value is not the expected next byte, or any other order of these steps, returns the guard to idle without programming.
- R5: Each guard step must arrive exactly `KEY_GAP` cycles after the previous one (default 2). A step that arrives early or late aborts the sequence with no write.
- R6: A write request is ignored unless control bit2 (write enable) was already 1 before the requesting bus write.
- R7: Write enable changes only through control writes. Clearing it while a write is busy does not cancel that write.
- R8: A launched write sets control bit1. Exactly `WRITE_CYCLES` cycles after launch, the byte is stored, bit1 clears, and bit3 and `irq` go high. Bit3 clears only when software writes the control register with bit3=0.
- R9: No write launches until `LOCK_CYCLES` cycles after reset release (default 64).
- R10: A read request made while a write is busy is ignored: the data register keeps its value and control bit0 stays 0.
- R11: Address register bits at and above log2(`DEPTH`) are kept in the register but do not select the array location (default depth 128).
- R12: Each byte needs its own full guard sequence. A second write request with no new key sequence does not launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Bus write strobe, one cycle per register write |
| busAddr | input | 2 | Register offset for reads and writes |
| busWdata | input | 8 | Bus write data |
| busRdata | output | 8 | Combinational read data of the register at `busAddr` |
| irq | output | 1 | Write-complete interrupt request, equal to control bit3 |

## Verification
A read result lands in the data register at the edge of the requesting bus write. The bench therefore reads the data register one cycle later, and the one-cycle read pulse is checked in the cycle between. The bench times write completion from the launch edge and expects `irq` at the first sample after `WRITE_CYCLES` edges. Guard steps are issued on precise cycle counts, with one bus operation per cycle and all driving done on the falling edge. This lets sequences that are on time, early and late be placed exactly. Each queued register expectation is compared 2 ns after the falling edge on which its offset is presented.

// File: rtl/eeg_pkg.sv
package eeg_pkg;
  typedef struct packed {
    logic loadAddr;
    logic loadData;
    logic doRead;
    logic launch;
    logic commit;
  } eegStrobes_t;

  localparam logic [1:0] REG_ADDR = 2'd0;
  localparam logic [1:0] REG_DATA = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_KEY  = 2'd3;

  localparam int CB_RD   = 0;
  localparam int CB_WS   = 1;
  localparam int CB_WE   = 2;
  localparam int CB_DONE = 3;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/eeg_ctrl.sv
module eeg_ctrl
  import eeg_pkg::*;
#(
  parameter int WRITE_CYCLES = 20,
  parameter int LOCK_CYCLES  = 64,
  parameter int KEY_GAP      = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic [1:0]  busAddr,
  input  logic [7:0]  busWdata,
  output eegStrobes_t strobes,
  output logic        weBit,
  output logic        wsBit,
  output logic        doneBit,
  output logic        rdFlag,
  output logic        lockedOut
);
  localparam int LW = (LOCK_CYCLES < 1) ? 1 : $clog2(LOCK_CYCLES + 1);
  localparam int TW = (WRITE_CYCLES < 2) ? 1 : $clog2(WRITE_CYCLES + 1);
  localparam int GW = (KEY_GAP < 2) ? 1 : $clog2(KEY_GAP + 1);

  typedef enum logic [1:0] {GUARD_IDLE, GUARD_FIRST, GUARD_SECOND} guardState_t;

  guardState_t guardState;
  logic [GW-1:0] gapCnt;
  logic [LW-1:0] lockCnt;
  logic [TW-1:0] wrCnt;

  logic ctrlWr, keyWr, startReq, onTime;

  assign ctrlWr   = busWe && (busAddr == REG_CTRL);
  assign keyWr    = busWe && (busAddr == REG_KEY);
  assign startReq = ctrlWr && busWdata[CB_WS];
  assign onTime   = (gapCnt == GW'(KEY_GAP - 1));

  // power-up lockout window
  generate
    if (LOCK_CYCLES < 1) begin : g_noLock
      assign lockedOut = 1'b0;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) lockCnt <= '0;
        else       lockCnt <= '0;
      end
    end else begin : g_lock
      assign lockedOut = (lockCnt != LW'(LOCK_CYCLES));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          lockCnt <= '0;
        else if (lockedOut) lockCnt <= lockCnt + 1'b1;
      end
    end
  endgenerate

  // unlock tracker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      guardState <= GUARD_IDLE;
      gapCnt     <= '0;
    end else begin
      case (guardState)
        GUARD_IDLE: begin
          if (keyWr && busWdata == KEY_FIRST) begin
            guardState <= GUARD_FIRST;
            gapCnt     <= '0;
          end
        end
        GUARD_FIRST: begin
          if (keyWr) begin
            if (onTime && busWdata == KEY_SECOND) begin
              guardState <= GUARD_SECOND;
              gapCnt     <= '0;
            end else begin
              guardState <= GUARD_IDLE;
            end
          end else if (startReq || onTime) begin
            guardState <= GUARD_IDLE;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        GUARD_SECOND: begin
          if (keyWr || startReq || onTime) guardState <= GUARD_IDLE;
          else                             gapCnt <= gapCnt + 1'b1;
        end
        default: guardState <= GUARD_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.loadAddr = busWe && (busAddr == REG_ADDR);
    strobes.loadData = busWe && (busAddr == REG_DATA);
    strobes.doRead   = ctrlWr && busWdata[CB_RD] && !wsBit;
    strobes.launch   = startReq && (guardState == GUARD_SECOND) && onTime &&
                       weBit && !lockedOut && !wsBit;
    strobes.commit   = wsBit && (wrCnt == '0);
  end

  // control bits and programming timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weBit   <= 1'b0;
      wsBit   <= 1'b0;
      doneBit <= 1'b0;
      rdFlag  <= 1'b0;
      wrCnt   <= '0;
    end else begin
      rdFlag <= strobes.doRead;
      if (ctrlWr) weBit <= busWdata[CB_WE];
      if (strobes.launch) begin
        wsBit <= 1'b1;
        wrCnt <= TW'(WRITE_CYCLES - 1);
      end else if (strobes.commit) begin
        wsBit <= 1'b0;
      end else if (wsBit) begin
        wrCnt <= wrCnt - 1'b1;
      end
      if (strobes.commit)                      doneBit <= 1'b1;
      else if (ctrlWr && !busWdata[CB_DONE])   doneBit <= 1'b0;
    end
  end
endmodule

// File: rtl/eeg_datapath.sv
module eeg_datapath
  import eeg_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  eegStrobes_t strobes,
  input  logic [7:0]  busWdata,
  output logic [7:0]  addrReg,
  output logic [7:0]  dataReg
);
  localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);

  logic [7:0]    cells [DEPTH];
  logic [AW-1:0] cellIdx;
  logic [AW-1:0] progAddr;
  logic [7:0]    progData;

  assign cellIdx = addrReg[AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      dataReg  <= '0;
      progAddr <= '0;
      progData <= '0;
    end else begin
      if (strobes.loadAddr) addrReg <= busWdata;
      if (strobes.loadData)    dataReg <= busWdata;
      else if (strobes.doRead) dataReg <= cells[cellIdx];
      if (strobes.launch) begin
        progAddr <= cellIdx;
        progData <= dataReg;
      end
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                          cells[i] <= '0;
        else if (strobes.commit && progAddr == AW'(i))      cells[i] <= progData;
      end
    end
  endgenerate
endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard
  import eeg_pkg::*;
#(
  parameter int DEPTH        = 128,
  parameter int WRITE_CYCLES = 20,
  parameter int LOCK_CYCLES  = 64,
  parameter int KEY_GAP      = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWe,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       irq
);
  eegStrobes_t strobes;
  logic weBit, wsBit, doneBit, rdFlag, lockedOut;
  logic [7:0] addrReg, dataReg;

  eeg_ctrl #(
    .WRITE_CYCLES(WRITE_CYCLES),
    .LOCK_CYCLES (LOCK_CYCLES),
    .KEY_GAP     (KEY_GAP)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strobes  (strobes),
    .weBit    (weBit),
    .wsBit    (wsBit),
    .doneBit  (doneBit),
    .rdFlag   (rdFlag),
    .lockedOut(lockedOut)
  );

  eeg_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .busWdata(busWdata),
    .addrReg (addrReg),
    .dataReg (dataReg)
  );

  always_comb begin
    case (busAddr)
      REG_ADDR: busRdata = addrReg;
      REG_DATA: busRdata = dataReg;
      REG_CTRL: busRdata = {4'b0, doneBit, weBit, wsBit, rdFlag};
      default:  busRdata = 8'h00;
    endcase
  end

  assign irq = doneBit;
endmodule

// File: rtl/eeg_chk.sv
module eeg_chk
  import eeg_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busWe,
  input logic [1:0]  busAddr,
  input logic [7:0]  busWdata,
  input logic        weBit,
  input logic        wsBit,
  input logic        doneBit,
  input logic        rdFlag,
  input logic        lockedOut,
  input logic        irq,
  input logic [7:0]  dataReg,
  input eegStrobes_t strobes
);
  p_launch_needs_we_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wsBit) |-> $past(weBit));

  p_launch_after_lockout_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wsBit) |-> !$past(lockedOut));

  p_we_only_by_sw_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(weBit) |-> $past(busWe && busAddr == REG_CTRL && !busWdata[CB_WE]));

  p_done_on_finish_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneBit) |-> $fell(wsBit));

  p_irq_tracks_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq == doneBit);

  p_read_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdFlag |=> !rdFlag);

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadData && !strobes.doRead) |=> $stable(dataReg));

  p_read_blocked_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wsBit && busWe && busAddr == REG_CTRL && busWdata[CB_RD]) |=> !rdFlag);
endmodule

bind eeprom_guard eeg_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .weBit    (weBit),
  .wsBit    (wsBit),
  .doneBit  (doneBit),
  .rdFlag   (rdFlag),
  .lockedOut(lockedOut),
  .irq      (irq),
  .dataReg  (dataReg),
  .strobes  (strobes)
);

// File: tb/eeprom_guard_tb.sv
module eeprom_guard_tb;
  localparam int W    = 20;
  localparam int LOCK = 64;
  localparam int GAP  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic irq;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] expVal;
    string      tag;
  } expItem_t;
  expItem_t pending[$];

  always #10 clk = ~clk;

  eeprom_guard #(.DEPTH(128), .WRITE_CYCLES(W), .LOCK_CYCLES(LOCK), .KEY_GAP(GAP)) u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  // monitor: compares each queued expectation against the register on the bus
  always @(negedge clk) begin
    #2;
    while (pending.size() > 0) begin
      expItem_t it;
      it = pending.pop_front();
      nRun++;
      if (busRdata !== it.expVal) begin
        nFail++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, busRdata, it.expVal);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busWe = 1'b0;
    end
  endtask

  task automatic peek(input logic [1:0] a, input logic [7:0] e, input string tag);
    expItem_t it;
    @(negedge clk);
    busWe = 1'b0; busAddr = a;
    it.expVal = e; it.tag = tag;
    pending.push_back(it);
  endtask

  // key steps with chosen spacing (in cycles) between them
  task automatic guardSeq(input logic [7:0] k1, input logic [7:0] k2, input int s1,
                          input int s2, input logic [7:0] ctl);
    wr(2'd3, k1);
    idle(s1 - 1);
    wr(2'd3, k2);
    idle(s2 - 1);
    wr(2'd2, ctl);
  endtask

  // returns the sample index at which irq was first seen (0 = never)
  task automatic waitIrq(output int k);
    k = 0;
    for (int i = 1; i <= 3 * W; i++) begin
      @(negedge clk);
      busWe = 1'b0;
      #1;
      if (irq && k == 0) k = i;
    end
  endtask

  task automatic readByte(input logic [7:0] a, input logic [7:0] e, input logic [7:0] weVal,
                          input string tag);
    wr(2'd0, a);
    wr(2'd2, weVal | 8'h01);
    peek(2'd1, e, tag);
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    peek(2'd0, 8'h00, "R1 addr reset");
    peek(2'd1, 8'h00, "R1 data reset");
    peek(2'd2, 8'h00, "R1 ctrl reset");
    chk(irq == 1'b0, "R1 irq reset", irq, 0);
    readByte(8'h05, 8'h00, 8'h00, "R1 array reset");

    // R9 lockout blocks a correct sequence
    wr(2'd2, 8'h04);
    wr(2'd0, 8'h10);
    wr(2'd1, 8'h3C);
    guardSeq(8'h55, 8'hAA, GAP, GAP, 8'h06);
    peek(2'd2, 8'h04, "R9 no launch during lockout");
    idle(LOCK + 10);
    readByte(8'h10, 8'h00, 8'h04, "R9 array untouched during lockout");

    // R4/R8 good write and timing
    wr(2'd1, 8'h3C);
    guardSeq(8'h55, 8'hAA, GAP, GAP, 8'h06);
    peek(2'd2, 8'h06, "R8 busy bit after launch");
    waitIrq(k);
    chk(k == W, "R8 completion cycle", k, W);
    peek(2'd2, 8'h0C, "R8 busy cleared, done set");
    wr(2'd2, 8'h0C);
    peek(2'd2, 8'h0C, "R8 done kept when writing 1");
    wr(2'd2, 8'h04);
    peek(2'd2, 8'h04, "R8 done cleared by software");
    chk(irq == 1'b0, "R8 irq low after clear", irq, 0);

    // R2 read timing and pulse
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h10);
    wr(2'd2, 8'h05);
    peek(2'd2, 8'h05, "R2 read pulse visible");
    peek(2'd1, 8'h3C, "R2 read data");
    peek(2'd2, 8'h04, "R2 read pulse cleared");

    // R3 data register hold and direct write
    wr(2'd1, 8'h77);
    peek(2'd1, 8'h77, "R3 direct data write");
    idle(5);
    peek(2'd1, 8'h77, "R3 data held");

    // R11 high address bits ignored
    readByte(8'h90, 8'h3C, 8'h04, "R11 aliased read");
    peek(2'd0, 8'h90, "R11 addr register keeps high bits");

    // R5 spacing: late, early, late start
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h11);
    guardSeq(8'h55, 8'hAA, GAP + 1, GAP, 8'h06);
    peek(2'd2, 8'h04, "R5 late second key");
    guardSeq(8'h55, 8'hAA, GAP - 1, GAP, 8'h06);
    peek(2'd2, 8'h04, "R5 early second key");
    guardSeq(8'h55, 8'hAA, GAP, GAP + 1, 8'h06);
    peek(2'd2, 8'h04, "R5 late start");

    // R4 wrong order and wrong values
    guardSeq(8'hAA, 8'h55, GAP, GAP, 8'h06);
    peek(2'd2, 8'h04, "R4 swapped keys");
    guardSeq(8'h55, 8'hAB, GAP, GAP, 8'h06);
    peek(2'd2, 8'h04, "R4 wrong second key");
    wr(2'd3, 8'h55); idle(GAP - 1); wr(2'd3, 8'hAA); idle(GAP - 1);
    wr(2'd3, 8'h55); idle(GAP - 1); wr(2'd2, 8'h06);
    peek(2'd2, 8'h04, "R4 extra key write resets guard");
    readByte(8'h20, 8'h00, 8'h04, "R4 R5 no byte programmed");

    // R6 write enable must already be set
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h11);
    guardSeq(8'h55, 8'hAA, GAP, GAP, 8'h02);
    peek(2'd2, 8'h00, "R6 blocked with enable clear");
    guardSeq(8'h55, 8'hAA, GAP, GAP, 8'h06);
    peek(2'd2, 8'h04, "R6 enable in same write not enough");
    readByte(8'h20, 8'h00, 8'h04, "R6 no byte programmed");

    // R7/R10 clear enable and try a read while busy
    wr(2'd0, 8'h30);
    wr(2'd1, 8'hA5);
    guardSeq(8'h55, 8'hAA, GAP, GAP, 8'h06);
    wr(2'd2, 8'h01);
    peek(2'd2, 8'h02, "R10 R7 busy kept, no read pulse, enable cleared");
    peek(2'd1, 8'hA5, "R10 data unchanged by read while busy");
    waitIrq(k);
    chk(k != 0, "R7 write completes after enable cleared", k, 1);
    peek(2'd2, 8'h08, "R7 enable stays clear, done set");
    wr(2'd1, 8'h00);
    readByte(8'h30, 8'hA5, 8'h04, "R7 byte stored");

    // R12 second request without a new sequence
    wr(2'd0, 8'h31);
    wr(2'd1, 8'h5A);
    wr(2'd2, 8'h06);
    peek(2'd2, 8'h04, "R12 no launch without new sequence");
    readByte(8'h31, 8'h00, 8'h04, "R12 no byte programmed");

    idle(2);
    finished = 1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    #5;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule